// File: doc/BRIEF.md
# Byte-Interleaved TDM Backplane Multiplexer

This block merges the channel bytes of up to four framed T1 receive streams onto one shared serial backplane bus. The bus runs at 8.192 Mb/s, and each 125 µs frame is 1024 bits, which is 128 byte slots. Every stream has a 7-bit slot offset and an enable. An enabled stream k places its channel n (n = 0 is the framing slot, n = 1..24 are payload channels) in slot (4·n + offset_k) mod 128. If two streams claim the same slot, the lowest-numbered stream wins. Slots that no enabled stream owns carry all-ones filler.

The block fetches bytes through a combinational request port. It drives `req_stream` and `req_chan`, raises `req_valid`, and the line side answers on `byte_in` and `sig_in` in the same cycle. A 4-bit signaling output (ABCD) stays aligned with the data slot. A frame-indicator output marks the F-bit of the lowest-numbered enabled stream.

Timing comes from one common clock. At 1x rate, one bit is sent per clock. At 2x rate, one bit is sent per two clocks. The frame pulse is sampled only on the first clock of each bit. A selectable clock (first or second) updates the outputs.

Top module: `tdm_byte_mux`

## Requirements
- R1: While reset is asserted, `sd_out` is 1, `sig_out` is 4'hF and `fi_out` sits at its inactive level, which equals `fp_inv`. The bit position restarts at 0 after reset.
- R2: The frame pulse is active when `fp_in ^ fp_inv` is 1. When it is sampled on a first clock, that bit period becomes frame position 0 (slot 0, bit 0). Positions then advance by one per bit period, modulo 1024. A pulse that arrives at any other position realigns the count to 0.
- R3: An enabled stream k owns slot (4·n + offset_k) mod 128 for n = 0..24. Offset_k is `stream_off[7k+6:7k]`. On a collision the lowest k wins. During a slot with no owner, `sd_out` is 1 and `sig_out` is 4'hF.
- R4: In the slot of stream k, channel n ≥ 1, the block presents `req_valid`=1, `req_stream`=k and `req_chan`=n. The returned `byte_in` is sent bit 7 first, down to bit 0.
- R5: In the framing slot (n = 0), the bits sent are `byte_in[7]` (parity) first, then six ones, then `byte_in[0]` (the F-bit) last. `sig_out` is 4'hF throughout that slot.
- R6: For channel n ≥ 1, `sig_out` equals that channel's `sig_in` for all eight bits of its slot. It changes only at a slot's first bit.
- R7: `fi_out` is active only during bit 7 of slot offset_f, where f is the lowest enabled stream. Its active level is the opposite of `fp_inv`. It never goes active when no stream is enabled.
- R8: With `rate_2x`=0, the outputs advance one bit per clock. With `rate_2x`=1, they advance one bit per two clocks, and a frame pulse seen on a second clock is ignored. On a clock that is not the update clock, the outputs hold their values.
- R9: At 2x rate, the outputs update on the second clock of each bit when `upd_second`=1 and `fp_fall_sel`==`out_rise_sel`. In every other case they update on the first clock, which is the same clock that samples the frame pulse. Second-clock update adds one clock of latency.
- R10: A disabled stream is never requested and never drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common system clock, 1x or 2x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_2x | input | 1 | 1 = two clocks per bus bit |
| upd_second | input | 1 | In 2x mode, request output update on the second clock |
| fp_fall_sel | input | 1 | Frame-pulse sampling edge select |
| out_rise_sel | input | 1 | Output update edge select; when it differs from `fp_fall_sel`, `upd_second` is ignored |
| fp_inv | input | 1 | 1 = frame pulse and frame indicator active low |
| fp_in | input | 1 | Common frame pulse marking frame position 0 |
| stream_en | input | 4 | Per-stream bus enable |
| stream_off | input | 28 | Per-stream 7-bit slot offset, stream k at bits 7k+6:7k |
| req_valid | output | 1 | Current slot belongs to an enabled stream |
| req_stream | output | 2 | Stream whose byte is requested |
| req_chan | output | 5 | Channel requested (0 = framing slot) |
| byte_in | input | 8 | Requested channel byte, or parity/F-bit for channel 0 |
| sig_in | input | 4 | Requested channel ABCD signaling bits |
| sd_out | output | 1 | Serial backplane data |
| sig_out | output | 4 | Slot-aligned signaling bits |
| fi_out | output | 1 | Frame indicator for the lowest enabled stream |

## Verification
The assertions check cycle-level rules on every clock:
- the bit counter advances by exactly one per bit period and realigns on a frame pulse;
- the counter holds on second clocks at 2x rate;
- no output changes on a non-update clock;
- `sig_out` stays steady inside a slot;
- a disabled stream is never requested;
- unowned slots carry filler;
- the frame indicator is inactive away from bit 7.

Only the bench's scenarios can show that whole frames come out bit-exact for different offset sets, enable masks, polarities, rates and update-clock choices. The same holds for the offset wrap past slot 127, for realignment after a mid-frame pulse, and for ignoring a pulse on a second clock.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

    localparam int BYTE_W = 8;
    localparam int SIG_W  = 4;

    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;
    localparam logic [SIG_W-1:0]  FILL_SIG  = '1;

    // Output stage state of the serialiser
    typedef struct packed {
        logic              sd;
        logic [SIG_W-1:0]  sig;
        logic              fi;
        logic [BYTE_W-1:0] octet;
    } ser_state_t;

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_2x,
    input  logic             upd_late,
    input  logic             fp_act,
    output logic             upd_now,
    output logic [POS_W-1:0] upd_pos
);

    typedef struct packed {
        logic             phase;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] cur;
    } tmr_t;

    tmr_t st_d, st_q;
    logic first_clk;
    logic fp_hit;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        st_d      = st_q;
        first_clk = !rate_2x || !st_q.phase;
        fp_hit    = first_clk && fp_act;
        cur_pos   = fp_hit ? '0 : st_q.pos;
        st_d.phase = rate_2x ? !st_q.phase : 1'b0;
        if (first_clk) begin
            st_d.pos = cur_pos + 1'b1;
            st_d.cur = cur_pos;
        end
        if (!rate_2x) begin
            upd_now = 1'b1;
            upd_pos = cur_pos;
        end else if (upd_late) begin
            upd_now = st_q.phase;
            upd_pos = st_q.cur;
        end else begin
            upd_now = !st_q.phase;
            upd_pos = cur_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    pos_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_clk && !fp_act) |=> st_q.pos == $past(st_q.pos) + 1'b1);

    // R2
    fp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_clk && fp_act) |=> st_q.pos == POS_W'(1));

    // R8
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_2x && st_q.phase) |=> $stable(st_q.pos));

endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode #(
    parameter int NS     = 4,
    parameter int OFF_W  = 7,
    parameter int CH_CNT = 24,
    parameter int IDX_W  = 2,
    parameter int CH_W   = 5
) (
    input  logic [OFF_W-1:0]    slot,
    input  logic [NS-1:0]       en,
    input  logic [NS*OFF_W-1:0] offs,
    output logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [CH_W-1:0]     chan,
    output logic                any_en,
    output logic [OFF_W-1:0]    first_off
);

    localparam logic [OFF_W-1:0] STRIDE = OFF_W'(NS);
    localparam logic [OFF_W-1:0] LAST_N = OFF_W'(CH_CNT);

    logic [NS-1:0]   own;
    logic [CH_W-1:0] chn [NS];

    for (genvar k = 0; k < NS; k++) begin : g_st
        logic [OFF_W-1:0] rel;
        assign rel    = slot - offs[k*OFF_W +: OFF_W];
        assign own[k] = en[k] && ((rel % STRIDE) == '0) && ((rel / STRIDE) <= LAST_N);
        assign chn[k] = CH_W'(rel / STRIDE);
    end

    always_comb begin
        hit       = 1'b0;
        idx       = '0;
        chan      = '0;
        any_en    = 1'b0;
        first_off = '0;
        for (int k = NS - 1; k >= 0; k--) begin
            if (own[k]) begin
                hit  = 1'b1;
                idx  = IDX_W'(k);
                chan = chn[k];
            end
            if (en[k]) begin
                any_en    = 1'b1;
                first_off = offs[k*OFF_W +: OFF_W];
            end
        end
    end

endmodule

// File: rtl/tdm_byte_mux.sv
module tdm_byte_mux
    import tdm_mux_pkg::*;
#(
    parameter int NS     = 4,
    parameter int OFF_W  = 7,
    parameter int CH_CNT = 24,
    localparam int POS_W = OFF_W + 3,
    localparam int IDX_W = $clog2(NS),
    localparam int CH_W  = $clog2(CH_CNT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rate_2x,
    input  logic                upd_second,
    input  logic                fp_fall_sel,
    input  logic                out_rise_sel,
    input  logic                fp_inv,
    input  logic                fp_in,
    input  logic [NS-1:0]       stream_en,
    input  logic [NS*OFF_W-1:0] stream_off,
    output logic                req_valid,
    output logic [IDX_W-1:0]    req_stream,
    output logic [CH_W-1:0]     req_chan,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic [SIG_W-1:0]    sig_in,
    output logic                sd_out,
    output logic [SIG_W-1:0]    sig_out,
    output logic                fi_out
);

    logic             upd_late;
    logic             upd_now;
    logic [POS_W-1:0] upd_pos;
    logic [2:0]       upd_bit;
    logic [OFF_W-1:0] upd_slot;
    logic             any_en;
    logic [OFF_W-1:0] first_off;
    logic [BYTE_W-1:0] slot_byte;

    ser_state_t ser_d, ser_q;

    assign upd_late = rate_2x && upd_second && (fp_fall_sel == out_rise_sel);
    assign upd_bit  = upd_pos[2:0];
    assign upd_slot = upd_pos[POS_W-1:3];

    tdm_bit_timer #(.POS_W(POS_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_2x  (rate_2x),
        .upd_late (upd_late),
        .fp_act   (fp_in ^ fp_inv),
        .upd_now  (upd_now),
        .upd_pos  (upd_pos)
    );

    tdm_slot_decode #(
        .NS(NS), .OFF_W(OFF_W), .CH_CNT(CH_CNT), .IDX_W(IDX_W), .CH_W(CH_W)
    ) u_decode (
        .slot      (upd_slot),
        .en        (stream_en),
        .offs      (stream_off),
        .hit       (req_valid),
        .idx       (req_stream),
        .chan      (req_chan),
        .any_en    (any_en),
        .first_off (first_off)
    );

    always_comb begin
        ser_d = ser_q;
        if (!req_valid)
            slot_byte = FILL_BYTE;
        else if (req_chan == '0)
            slot_byte = {byte_in[7], 6'h3F, byte_in[0]};
        else
            slot_byte = byte_in;

        if (upd_now) begin
            if (upd_bit == 3'd0) begin
                ser_d.octet = slot_byte;
                ser_d.sd    = slot_byte[7];
                ser_d.sig   = (req_valid && req_chan != '0) ? sig_in : FILL_SIG;
            end else begin
                ser_d.sd = ser_q.octet[3'd7 - upd_bit];
            end
            ser_d.fi = any_en && (upd_slot == first_off) && (upd_bit == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '{sd: 1'b1, sig: FILL_SIG, fi: 1'b0, octet: FILL_BYTE};
        else        ser_q <= ser_d;
    end

    assign sd_out  = ser_q.sd;
    assign sig_out = ser_q.sig;
    assign fi_out  = ser_q.fi ^ fp_inv;

    // R10
    req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> stream_en[req_stream]);

    // R3
    filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_now && upd_bit == 3'd0 && !req_valid) |=> (sd_out && sig_out == FILL_SIG));

    // R6
    sig_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_now && upd_bit != 3'd0) |=> $stable(sig_out));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_now |=> ($stable(sd_out) && $stable(sig_out) && $stable(fi_out)));

    // R7
    fi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_now && upd_bit != 3'd7) |=> fi_out == fp_inv);

endmodule

// File: tb/tdm_byte_mux_tb.sv
`timescale 1ns/1ps
module tdm_byte_mux_tb;

    typedef struct packed {
        logic        rate2x;
        logic        upd2;
        logic        fpfall;
        logic        outrise;
        logic        inv;
        logic [3:0]  en;
        logic [27:0] off;
    } vec_t;

    // rate2x upd2 fpfall outrise inv en off{s3,s2,s1,s0}
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, {7'd3, 7'd2, 7'd1, 7'd0}},     // R3 R4 R5 base
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, {7'd43, 7'd42, 7'd41, 7'd40}}, // R3 wrap, R7 polarity
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hA, {7'd3, 7'd2, 7'd1, 7'd0}},     // R10 R7 first enabled
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, {7'd3, 7'd2, 7'd1, 7'd0}},     // R8 first clock
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, {7'd3, 7'd2, 7'd1, 7'd0}},     // R9 second clock
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, {7'd3, 7'd2, 7'd1, 7'd0}},     // R9 mismatch
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, {7'd3, 7'd2, 7'd1, 7'd0}},     // R10 none enabled
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, {7'd0, 7'd1, 7'd2, 7'd3}}      // R3 reversed
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_2x = 1'b0, upd_second = 1'b0, fp_fall_sel = 1'b0, out_rise_sel = 1'b0;
    logic fp_inv = 1'b0, fp_in = 1'b0;
    logic [3:0] stream_en = '0;
    logic [27:0] stream_off = '0;
    logic req_valid;
    logic [1:0] req_stream;
    logic [4:0] req_chan;
    logic [7:0] byte_in;
    logic [3:0] sig_in;
    logic sd_out;
    logic [3:0] sig_out;
    logic fi_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int s, input int c);
        return 8'((s * 101 + c * 11 + 133) % 256);
    endfunction

    function automatic logic [3:0] mem_sig(input int s, input int c);
        return 4'((s * 5 + c * 3 + 1) % 16);
    endfunction

    assign byte_in = mem_byte(int'(req_stream), int'(req_chan));
    assign sig_in  = mem_sig(int'(req_stream), int'(req_chan));

    tdm_byte_mux u_dut (
        .clk(clk), .rst_n(rst_n), .rate_2x(rate_2x), .upd_second(upd_second),
        .fp_fall_sel(fp_fall_sel), .out_rise_sel(out_rise_sel), .fp_inv(fp_inv),
        .fp_in(fp_in), .stream_en(stream_en), .stream_off(stream_off),
        .req_valid(req_valid), .req_stream(req_stream), .req_chan(req_chan),
        .byte_in(byte_in), .sig_in(sig_in), .sd_out(sd_out), .sig_out(sig_out),
        .fi_out(fi_out)
    );

    // Expected {sd, sig, fi} at frame position pos
    function automatic logic [5:0] model(input vec_t v, input int pos, output string tag);
        int slot = pos / 8;
        int b = pos % 8;
        logic sd = 1'b1;
        logic [3:0] sg = 4'hF;
        logic fi = 1'b0;
        logic [7:0] by;
        bit found = 0;
        int ks = 0, ns = 0;
        tag = "R3";
        for (int k = 0; k < 4; k++) begin
            if (!found && v.en[k]) begin
                for (int n = 0; n <= 24; n++) begin
                    if (!found && ((4 * n + int'(v.off[7*k +: 7])) % 128) == slot) begin
                        found = 1; ks = k; ns = n;
                    end
                end
            end
        end
        if (found) begin
            by = mem_byte(ks, ns);
            if (ns == 0) begin
                by = {by[7], 6'h3F, by[0]};
                tag = "R5";
            end else begin
                sg = mem_sig(ks, ns);
                tag = "R4/R6";
            end
            sd = by[7 - b];
        end
        for (int k = 3; k >= 0; k--) begin
            if (v.en[k]) fi = (slot == int'(v.off[7*k +: 7])) && (b == 7);
        end
        if (fi) tag = "R7";
        return {sd, sg, fi ^ v.inv};
    endfunction

    task automatic check_pos(input vec_t v, input int pos, input string lbl);
        string tag;
        logic [5:0] exp = model(v, pos, tag);
        logic [5:0] act = {sd_out, sig_out, fi_out};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s pos %0d: actual sd=%b sig=%h fi=%b expected sd=%b sig=%h fi=%b",
                     tag, lbl, pos, act[5], act[4:1], act[0], exp[5], exp[4:1], exp[0]);
        end
    endtask

    // Resets, checks reset state (R1), issues the frame pulse (R2)
    task automatic start(input vec_t v);
        @(negedge clk);
        rst_n = 1'b0;
        rate_2x = v.rate2x; upd_second = v.upd2;
        fp_fall_sel = v.fpfall; out_rise_sel = v.outrise;
        fp_inv = v.inv; fp_in = v.inv;
        stream_en = v.en; stream_off = v.off;
        repeat (2) @(negedge clk);
        n_chk++;
        if ({sd_out, sig_out, fi_out} !== {1'b1, 4'hF, v.inv}) begin
            n_fail++;
            $display("FAIL R1 reset: actual sd=%b sig=%h fi=%b expected sd=1 sig=f fi=%b",
                     sd_out, sig_out, fi_out, v.inv);
        end
        rst_n = 1'b1;
        fp_in = ~v.inv;
        @(negedge clk);
        fp_in = v.inv;
        if (v.rate2x && v.upd2 && (v.fpfall == v.outrise)) @(negedge clk); // R9 latency
    endtask

    task automatic follow(input vec_t v, input int p0, input int cnt, input string lbl);
        int step = v.rate2x ? 2 : 1;
        for (int i = 0; i < cnt; i++) begin
            check_pos(v, (p0 + i) % 1024, lbl);
            if (i != cnt - 1) repeat (step) @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Table walk: whole frame per vector, plus wrap into the next frame (R2)
        for (int vi = 0; vi < 8; vi++) begin
            start(VECS[vi]);
            follow(VECS[vi], 0, 1040, $sformatf("vec%0d", vi));
        end

        // R2: mid-frame pulse realigns to position 0
        start(VECS[0]);
        follow(VECS[0], 0, 300, "R2 pre");
        fp_in = ~VECS[0].inv;
        @(negedge clk);
        fp_in = VECS[0].inv;
        follow(VECS[0], 0, 60, "R2 resync");

        // R8: pulse on a second clock at 2x rate is ignored
        start(VECS[3]);
        follow(VECS[3], 0, 100, "R8 pre");
        fp_in = ~VECS[3].inv;
        @(negedge clk);
        fp_in = VECS[3].inv;
        check_pos(VECS[3], 99, "R8 hold");
        @(negedge clk);
        follow(VECS[3], 100, 60, "R8 ignored pulse");

        // R1: reset mid-run returns outputs to idle levels
        start(VECS[1]);
        follow(VECS[1], 0, 20, "R1 pre");
        start(VECS[1]);
        follow(VECS[1], 0, 20, "R1 post");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule